// File: doc/BRIEF.md
# Collision and Heartbeat Signaller

This block generates the collision-presence waveform that a coaxial transceiver returns to its host controller. Three sources can request signalling. The first is a collision flag from an upstream comparator. The second is a jabber request from the transmit watchdog. The third is an internal self-test that fires after every transmission. While any source is active, the block drives a square wave at one tenth of its clock rate. The default clock is 100 MHz, which gives a 10 MHz wave with 50 ns low and 50 ns high halves.

Each burst opens with a low half-period. When all sources have gone quiet, the block finishes the period it is in and then holds the output high for a fixed tail before it returns to idle. The self-test burst waits about 1 µs after transmit-active falls and then lasts about 1 µs. A strap input suppresses the self-test. Overlapping requests merge into a single burst with a single tail. The `busy` output marks the span from the first low half to the end of the tail. A downstream line driver uses it as its enable.

Top module: `cdsig_top`

## Requirements
- R1: After reset and whenever no burst is in progress, `cd_busy` is 0 and `cd_wave` is 1 (idle level).
- R2: The first cycle in which `cd_busy` is 1 always has `cd_wave` = 0, so every burst starts with a low pulse.
- R3: During oscillation, every low run and every non-final high run of `cd_wave` lasts exactly 5 clock cycles (50 ns at 100 MHz, inside the 35–70 ns window).
- R4: Every burst ends with a continuous high run of at least 25 cycles (250 ns, above 170 ns) before `cd_busy` returns to 0.
- R5: A collision or jabber request that starts while the block is idle raises `cd_busy` on the next clock edge, which is well within 13 bit times (130 cycles).
- R6: After the last request clears, `cd_busy` falls within 160 cycles (16 bit times).
- R7: When `hb_en` is 1, a falling edge of `tx_act` starts a self-test burst between 60 and 160 cycles later (0.6–1.6 µs).
- R8: The oscillating part of a self-test burst lasts between 50 and 150 cycles (0.5–1.5 µs).
- R9: When `hb_en` is 0 at the fall of `tx_act`, no burst follows.
- R10: A jabber request produces a burst regardless of `hb_en`.
- R11: A collision that arrives during a self-test burst extends that burst. Exactly one tail is produced, and no second burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| coll_det | input | 1 | Collision condition flag from the comparator |
| tx_act | input | 1 | High while the host is transmitting |
| hb_en | input | 1 | Self-test strap: 1 enables the post-transmit burst |
| jab_act | input | 1 | Jabber request |
| cd_wave | output | 1 | Collision waveform; 1 when idle |
| cd_busy | output | 1 | High from the first low pulse until the tail ends |

## Verification
The bench measures every run of the waveform. A divider that starts in the wrong phase would open a burst with a high pulse. A counter that is off by one would give 4- or 6-cycle halves. Both faults show up in the run lengths. It times the self-test delay and length against the spec windows, which catches wait or length counters that are wrong or never finish. It also checks that the strap really suppresses the burst. The overlap case puts a collision inside a self-test burst. A design that restarted, or that emitted a tail when the self-test ended, would show a short high run or a second burst.

// File: rtl/cdsig_pkg.sv
package cdsig_pkg;
  typedef enum logic [1:0] {SG_IDLE, SG_OSC, SG_TAIL} sig_st_e;
  typedef enum logic [1:0] {HB_IDLE, HB_WAIT, HB_BURST} hb_st_e;

  // Round a duration in ns up to whole clock cycles.
  function automatic int ns_to_cyc(input int clk_mhz, input int ns);
    return (clk_mhz * ns + 999) / 1000;
  endfunction

  // Half period of the 10 MHz wave in clock cycles.
  function automatic int half_cyc(input int clk_mhz);
    return clk_mhz / 20;
  endfunction
endpackage

// File: rtl/cdsig_hb.sv
module cdsig_hb
  import cdsig_pkg::*;
#(
  parameter int WAIT_CYC = 100,
  parameter int LEN_CYC  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic hb_en,
  output logic hb_req
);
  localparam int MAXC = (WAIT_CYC > LEN_CYC) ? WAIT_CYC : LEN_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] LEN_LAST  = CW'(LEN_CYC - 1);

  hb_st_e         st;
  logic [CW-1:0]  cnt;
  logic           tx_q;
  logic           tx_fall;

  assign tx_fall = tx_q && !tx_act;
  assign hb_req  = (st == HB_BURST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= HB_IDLE;
      cnt  <= '0;
      tx_q <= 1'b0;
    end else begin
      tx_q <= tx_act;
      if (tx_fall && hb_en) begin
        st  <= HB_WAIT;
        cnt <= '0;
      end else begin
        unique case (st)
          HB_WAIT: begin
            if (tx_act) st <= HB_IDLE;
            else if (cnt == WAIT_LAST) begin
              st  <= HB_BURST;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          HB_BURST: begin
            if (cnt == LEN_LAST) st <= HB_IDLE;
            else cnt <= cnt + 1'b1;
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  // R9: with the strap off, a transmit end never arms the self-test.
  assert_strap_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fall && !hb_en && st == HB_IDLE) |=> (st == HB_IDLE));
endmodule

// File: rtl/cdsig_burst.sv
module cdsig_burst
  import cdsig_pkg::*;
#(
  parameter int HALF_CYC = 5,
  parameter int TAIL_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic wave,
  output logic busy
);
  localparam int PER = 2 * HALF_CYC;
  localparam int PW  = $clog2(PER);
  localparam int TW  = $clog2(TAIL_CYC + 1);
  localparam int RW  = $clog2(PER + TAIL_CYC + 2);
  localparam logic [PW-1:0] PH_LAST   = PW'(PER - 1);
  localparam logic [PW-1:0] PH_HIGH   = PW'(HALF_CYC);
  localparam logic [TW-1:0] TAIL_LAST = TW'(TAIL_CYC - 1);
  localparam logic [RW-1:0] RUN_MAX   = {RW{1'b1}};

  sig_st_e        st;
  logic [PW-1:0]  ph;
  logic [TW-1:0]  tcnt;
  logic           period_end;

  assign period_end = (st == SG_OSC) && (ph == PH_LAST);
  assign wave = (st == SG_OSC) ? (ph >= PH_HIGH) : 1'b1;
  assign busy = (st != SG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SG_IDLE;
      ph   <= '0;
      tcnt <= '0;
    end else begin
      unique case (st)
        SG_IDLE: if (req) begin
          st <= SG_OSC;
          ph <= '0;
        end
        SG_OSC: begin
          if (period_end) begin
            ph <= '0;
            if (!req) begin
              st   <= SG_TAIL;
              tcnt <= '0;
            end
          end else ph <= ph + 1'b1;
        end
        default: begin
          if (req) begin
            st <= SG_OSC;
            ph <= '0;
          end else if (tcnt == TAIL_LAST) st <= SG_IDLE;
          else tcnt <= tcnt + 1'b1;
        end
      endcase
    end
  end

  // Checker state: length of the current high run while busy.
  logic [RW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else if (busy && wave) hi_run <= (hi_run == RUN_MAX) ? hi_run : hi_run + 1'b1;
    else hi_run <= '0;
  end

  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> wave);
  assert_first_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wave);
  assert_low_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $fell(wave)) |=> !wave);
  assert_tail_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (hi_run >= RW'(TAIL_CYC)));
endmodule

// File: rtl/cdsig_top.sv
module cdsig_top
  import cdsig_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int HB_WAIT_NS = 1000,
  parameter int HB_LEN_NS  = 1000,
  parameter int TAIL_NS    = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic coll_det,
  input  logic tx_act,
  input  logic hb_en,
  input  logic jab_act,
  output logic cd_wave,
  output logic cd_busy
);
  localparam int HALF_CYC = half_cyc(CLK_MHZ);
  localparam int WAIT_CYC = ns_to_cyc(CLK_MHZ, HB_WAIT_NS);
  localparam int LEN_CYC  = ns_to_cyc(CLK_MHZ, HB_LEN_NS);
  localparam int TAIL_CYC = ns_to_cyc(CLK_MHZ, TAIL_NS);

  logic hb_req;
  logic any_req;

  cdsig_hb #(.WAIT_CYC(WAIT_CYC), .LEN_CYC(LEN_CYC)) hb_i (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .hb_en(hb_en), .hb_req(hb_req)
  );

  assign any_req = coll_det | jab_act | hb_req;

  cdsig_burst #(.HALF_CYC(HALF_CYC), .TAIL_CYC(TAIL_CYC)) burst_i (
    .clk(clk), .rst_n(rst_n), .req(any_req), .wave(cd_wave), .busy(cd_busy)
  );

  // R5 and R10: an external request from idle raises busy on the next edge.
  assert_fast_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cd_busy && (coll_det || jab_act)) |=> cd_busy);
endmodule

// File: tb/cdsig_top_tb_top.sv
module cdsig_top_tb_top;
  localparam int HALF = 5;
  localparam int TAIL = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coll_det = 1'b0, tx_act = 1'b0, hb_en = 1'b1, jab_act = 1'b0;
  logic cd_wave, cd_busy;
  int n_chk = 0, n_err = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cdsig_top dut_i (
    .clk(clk), .rst_n(rst_n), .coll_det(coll_det), .tx_act(tx_act),
    .hb_en(hb_en), .jab_act(jab_act), .cd_wave(cd_wave), .cd_busy(cd_busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // Waits for a burst and measures it at negedges.
  task automatic capture(input int tmo, output int dly, output int blen,
                         output int first_w, output int minlo, output int maxlo,
                         output int minhi, output int maxhi, output int last_hi);
    int rv, rl;
    dly = 0; blen = 0; first_w = 1; minlo = 999; maxlo = 0;
    minhi = 999; maxhi = 0; last_hi = 0;
    while (!cd_busy && dly < tmo) begin @(negedge clk); dly++; end
    if (!cd_busy) begin dly = -1; return; end
    first_w = cd_wave; rv = cd_wave; rl = 0;
    while (cd_busy) begin
      if (cd_wave != rv) begin
        if (rv == 0) begin minlo = (rl < minlo) ? rl : minlo; maxlo = (rl > maxlo) ? rl : maxlo; end
        else begin minhi = (rl < minhi) ? rl : minhi; maxhi = (rl > maxhi) ? rl : maxhi; end
        rv = cd_wave; rl = 0;
      end
      rl++; blen++;
      @(negedge clk);
    end
    last_hi = (rv == 1) ? rl : 0;
  endtask

  task automatic t_reset;
    chk(cd_busy == 1'b0, "R1 busy at reset", cd_busy, 0);
    chk(cd_wave == 1'b1, "R1 idle level", cd_wave, 1);
  endtask

  task automatic t_collision;
    int d, b, fw, lo0, lo1, hi0, hi1, lh;
    hb_en = 1'b0;
    fork
      capture(20, d, b, fw, lo0, lo1, hi0, hi1, lh);
      begin coll_det = 1'b1; repeat (300) @(negedge clk); coll_det = 1'b0; end
    join
    chk(d == 1, "R5 start delay", d, 1);
    chk(fw == 0, "R2 first low", fw, 0);
    chk(lo0 == HALF && lo1 == HALF, "R3 low run", lo1, HALF);
    chk(hi0 == HALF && hi1 == HALF, "R3 high run", hi1, HALF);
    chk(lh >= TAIL && lh > 17, "R4 tail", lh, TAIL);
    chk((d + b - 300) <= 160 && (d + b - 300) >= TAIL, "R6 stop delay", d + b - 300, 160);
    chk(cd_wave == 1'b1 && cd_busy == 1'b0, "R1 back to idle", cd_busy, 0);
  endtask

  task automatic t_heartbeat;
    int d, b, fw, lo0, lo1, hi0, hi1, lh;
    hb_en = 1'b1;
    tx_act = 1'b1; repeat (40) @(negedge clk); tx_act = 1'b0;
    capture(400, d, b, fw, lo0, lo1, hi0, hi1, lh);
    chk(d >= 60 && d <= 160, "R7 self-test delay", d, 100);
    chk((b - lh + HALF) >= 50 && (b - lh + HALF) <= 150, "R8 self-test length", b - lh + HALF, 100);
    chk(fw == 0, "R2 self-test first low", fw, 0);
    chk(lh >= TAIL, "R4 self-test tail", lh, TAIL);
  endtask

  task automatic t_hb_off;
    int d, b, fw, lo0, lo1, hi0, hi1, lh;
    hb_en = 1'b0;
    tx_act = 1'b1; repeat (40) @(negedge clk); tx_act = 1'b0;
    capture(400, d, b, fw, lo0, lo1, hi0, hi1, lh);
    chk(d == -1, "R9 no burst with strap off", d, -1);
    hb_en = 1'b1;
  endtask

  task automatic t_jabber;
    int d, b, fw, lo0, lo1, hi0, hi1, lh;
    hb_en = 1'b0;
    fork
      capture(20, d, b, fw, lo0, lo1, hi0, hi1, lh);
      begin jab_act = 1'b1; repeat (80) @(negedge clk); jab_act = 1'b0; end
    join
    chk(d == 1, "R10 jabber start", d, 1);
    chk(lo1 == HALF && fw == 0, "R10 jabber wave", lo1, HALF);
    chk((d + b - 80) <= 160, "R6 jabber stop", d + b - 80, 160);
    hb_en = 1'b1;
  endtask

  task automatic t_overlap;
    int d, b, fw, lo0, lo1, hi0, hi1, lh;
    int d2, b2, fw2, l0, l1, h0, h1, lh2;
    hb_en = 1'b1;
    tx_act = 1'b1; repeat (40) @(negedge clk); tx_act = 1'b0;
    fork
      capture(400, d, b, fw, lo0, lo1, hi0, hi1, lh);
      begin repeat (140) @(negedge clk); coll_det = 1'b1; repeat (200) @(negedge clk); coll_det = 1'b0; end
    join
    chk(b >= 200 + (140 - d), "R11 merged length", b, 200 + 140 - d);
    chk(hi0 == HALF && hi1 == HALF, "R11 no mid-burst tail", hi1, HALF);
    chk(lh >= TAIL, "R11 single tail", lh, TAIL);
    capture(300, d2, b2, fw2, l0, l1, h0, h1, lh2);
    chk(d2 == -1, "R11 no second burst", d2, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_collision;
    repeat (20) @(negedge clk);
    t_heartbeat;
    repeat (20) @(negedge clk);
    t_hb_off;
    t_jabber;
    repeat (20) @(negedge clk);
    t_overlap;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule